// File: doc/BRIEF.md
# SDRAM Command Sequencer with Bank Timing Guards

This block sits between a memory scheduler and the command pins of a four-bank SDRAM. The host presents one request at a time: open a row, read a column, write a column, close one or all banks, load the mode register, refresh, or stop a burst. The sequencer encodes the request as chip-select, row-strobe, column-strobe and write-enable levels plus bank and address. It holds the request back until every clock-count spacing that applies to the target bank, or to the whole device, has elapsed.

Each bank has its own row-open flag and three down-counters. One counts cycles until a column access is allowed. One counts cycles until the bank may be closed. One counts cycles until the bank may be opened again. A global state machine owns the device-wide waits. Its states are READY, MODE_HOLD and REF_HOLD. The transition READY→MODE_HOLD happens when a mode load is issued, READY→REF_HOLD when a refresh is issued, and either hold state returns to READY when its hold counter reaches zero. The same machine also tracks the spacing between activates to different banks. A request that breaks the row protocol is refused with a one-cycle error pulse instead of being sent.

The handshake works as follows. `req_ready` shows that the request currently on the request lines can be taken this cycle. A request is taken in any cycle where `req_valid` and `req_ready` are both high. Its command appears on the pins in the next cycle. In every other cycle after reset the pins carry a no-operation.

Top module: `sdram_cmd_seq`

## Requirements
- R1: Request codes on `req_op` are 0 open row, 1 read, 2 write, 3 close, 4 mode load, 5 refresh, 6 burst stop, 7 reserved. The pins {cs_n,ras_n,cas_n,we_n} for each are 0011, 0101, 0100, 0010, 0000, 0001, 0110. A no-operation is 0111 and deselect is 1111.
- R2: An open-row command drives `req_addr` on `addr`. A read or write drives column bits `req_addr[8:0]` on `addr[8:0]` and `req_flag` (auto-close) on `addr[10]`, with all other address bits zero. A close drives `req_flag` (all banks) on `addr[10]` and zero elsewhere. A mode load drives `req_addr` unchanged. `ba` carries `req_bank` for every issued command, and `addr` and `ba` are zero during a no-operation.
- R3: An accepted command appears on the pins exactly one cycle after acceptance. In reset the pins show deselect. After reset, any cycle with no accepted command shows a no-operation.
- R4: A read or write to a bank waits until T_RCD (default 2) cycles after that bank's open-row command.
- R5: Closing an open bank waits T_RAS (default 5) cycles after its open-row command and T_DPL (default 2) cycles after its last write. Close-all waits for every open bank.
- R6: An open-row command waits T_RC (default 7) cycles after the previous open of the same bank and T_RP (default 2) cycles after its close. It also waits T_RRD (default 2) cycles after any open-row command to any bank. All counters are satisfied out of reset.
- R7: A read with auto-close closes the bank. The bank may reopen T_RP cycles after the earliest cycle at which a close would have been legal, and no earlier than one cycle after the read. A write with auto-close also closes the bank; it may reopen after the larger of T_DAL (default 5) cycles and max(close wait, T_DPL)+T_RP cycles.
- R8: After a mode load, no request is taken for T_MRD (default 2) cycles.
- R9: A refresh is taken only when every bank is closed and its reopen wait has run out. After a refresh, no request is taken for T_RC cycles.
- R10: The following requests are refused: a read or write to a closed bank, an open-row command to an open bank, a mode load or refresh while any bank is open, and code 7. A refused request is taken with `req_error` high in the same cycle, and the pins show a no-operation in the next cycle.
- R11: `bank_open` shows which banks hold an open row. It updates one cycle after acceptance and clears on reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Request code (R1) |
| req_bank | input | 2 | Target bank |
| req_addr | input | 13 | Row, column or mode opcode |
| req_flag | input | 1 | Auto-close for read/write, all-banks for close |
| req_ready | output | 1 | Request can be taken this cycle |
| req_error | output | 1 | Request taken but refused |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank select |
| addr | output | 13 | Address bus |
| bank_open | output | 4 | Per-bank open-row flags |

## Verification
`req_ready` and `req_error` are combinational on the request lines, so the bench samples them one time step after it drives a request. It counts the falling edges that pass before `req_ready` rises, and compares that count with the wait worked out by hand from the spacings in R4 to R9. The pins and `bank_open` settle one clock after acceptance, so they are checked at the falling edge that follows the accepting rising edge, and the next request is presented at that same point. Reset values are checked while reset is held. The claim that counters are satisfied out of reset is checked by a request presented in the first cycle after release, which must be taken at once.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [2:0] {
        REQ_ACT = 3'd0,
        REQ_RD  = 3'd1,
        REQ_WR  = 3'd2,
        REQ_PRE = 3'd3,
        REQ_MRS = 3'd4,
        REQ_REF = 3'd5,
        REQ_BST = 3'd6,
        REQ_RSV = 3'd7
    } req_op_e;

    typedef enum logic [1:0] {
        ST_READY     = 2'd0,
        ST_MODE_HOLD = 2'd1,
        ST_REF_HOLD  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_pins_t;

    localparam cmd_pins_t PINS_DESEL = cmd_pins_t'(4'b1111);
    localparam cmd_pins_t PINS_NOP   = cmd_pins_t'(4'b0111);
    localparam cmd_pins_t PINS_MRS   = cmd_pins_t'(4'b0000);
    localparam cmd_pins_t PINS_ACT   = cmd_pins_t'(4'b0011);
    localparam cmd_pins_t PINS_RD    = cmd_pins_t'(4'b0101);
    localparam cmd_pins_t PINS_WR    = cmd_pins_t'(4'b0100);
    localparam cmd_pins_t PINS_PRE   = cmd_pins_t'(4'b0010);
    localparam cmd_pins_t PINS_BST   = cmd_pins_t'(4'b0110);
    localparam cmd_pins_t PINS_REF   = cmd_pins_t'(4'b0001);

endpackage

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer #(
    parameter int T_RCD = 2,
    parameter int T_RAS = 5,
    parameter int T_RC  = 7,
    parameter int T_RP  = 2,
    parameter int T_DPL = 2,
    parameter int T_DAL = 5,
    parameter int CW    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_act,
    input  logic do_rd,
    input  logic do_wr,
    input  logic do_pre,
    input  logic auto_pc,
    output logic row_open,
    output logic rcd_ok,
    output logic pre_ok,
    output logic act_ok
);

    localparam logic [CW-1:0] L_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] L_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] L_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);
    localparam logic [CW-1:0] L_DPL = CW'(T_DPL - 1);
    localparam logic [CW-1:0] L_DAL = CW'(T_DAL - 1);
    localparam logic [CW-1:0] D_DPL = CW'(T_DPL);
    localparam logic [CW-1:0] D_RP  = CW'(T_RP);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] rcd_q, pre_q, act_q;
    logic [CW-1:0] rcd_d, pre_d, act_d;
    logic [CW-1:0] rcd_n, pre_n, act_n;
    logic [CW-1:0] rd_base, wr_base, wr_sum, ld;
    logic          open_q, open_n;

    always_comb begin
        rcd_d = (rcd_q != '0) ? rcd_q - ONE : '0;
        pre_d = (pre_q != '0) ? pre_q - ONE : '0;
        act_d = (act_q != '0) ? act_q - ONE : '0;

        rcd_n = do_act ? L_RCD : rcd_d;

        pre_n = pre_d;
        if (do_act && (L_RAS > pre_n)) pre_n = L_RAS;
        if (do_wr && (L_DPL > pre_n))  pre_n = L_DPL;

        rd_base = (pre_q > ONE) ? pre_q : ONE;
        wr_base = (pre_q > D_DPL) ? pre_q : D_DPL;
        wr_sum  = wr_base + D_RP;

        ld = '0;
        if (do_act) ld = L_RC;
        if (do_pre) ld = L_RP;
        if (do_rd && auto_pc) ld = rd_base + L_RP;
        if (do_wr && auto_pc) ld = (wr_sum > CW'(T_DAL)) ? wr_sum - ONE : L_DAL;
        act_n = (act_d > ld) ? act_d : ld;

        open_n = open_q;
        if (do_act) open_n = 1'b1;
        if (do_pre || ((do_rd || do_wr) && auto_pc)) open_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_q  <= '0;
            pre_q  <= '0;
            act_q  <= '0;
            open_q <= 1'b0;
        end else begin
            rcd_q  <= rcd_n;
            pre_q  <= pre_n;
            act_q  <= act_n;
            open_q <= open_n;
        end
    end

    assign row_open = open_q;
    assign rcd_ok   = (rcd_q == '0);
    assign pre_ok   = (pre_q == '0);
    assign act_ok   = (act_q == '0);

    // R4
    col_after_rcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd || do_wr) |-> (rcd_q == '0 && open_q));

    // R6
    open_after_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (act_q == '0 && !open_q));

    // R5
    close_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_pre && open_q) |-> (pre_q == '0));

    // R7
    auto_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((do_rd || do_wr) && auto_pc) |=> !open_q);

endmodule

// File: rtl/sdram_seq_fsm.sv
module sdram_seq_fsm
    import sdram_seq_pkg::*;
#(
    parameter int T_MRD = 2,
    parameter int T_RFC = 7,
    parameter int T_RRD = 2,
    parameter int HW    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic do_mrs,
    input  logic do_ref,
    input  logic do_act,
    output logic cmd_ready,
    output logic rrd_ok
);

    localparam logic [HW-1:0] HOLD_MRS = (T_MRD > 1) ? HW'(T_MRD - 2) : '0;
    localparam logic [HW-1:0] HOLD_REF = (T_RFC > 1) ? HW'(T_RFC - 2) : '0;
    localparam logic [HW-1:0] L_RRD    = HW'(T_RRD - 1);

    seq_state_e    state_q, state_n;
    logic [HW-1:0] hold_q, hold_n;
    logic [HW-1:0] rrd_q, rrd_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            hold_q  <= '0;
            rrd_q   <= '0;
        end else begin
            state_q <= state_n;
            hold_q  <= hold_n;
            rrd_q   <= rrd_n;
        end
    end

    always_comb begin
        state_n = state_q;
        hold_n  = hold_q;
        unique case (state_q)
            ST_READY: begin
                if (do_mrs && (T_MRD > 1)) begin
                    state_n = ST_MODE_HOLD;
                    hold_n  = HOLD_MRS;
                end else if (do_ref && (T_RFC > 1)) begin
                    state_n = ST_REF_HOLD;
                    hold_n  = HOLD_REF;
                end
            end
            ST_MODE_HOLD, ST_REF_HOLD: begin
                if (hold_q == '0) state_n = ST_READY;
                else              hold_n  = hold_q - HW'(1);
            end
            default: state_n = ST_READY;
        endcase
        rrd_n = do_act ? L_RRD : ((rrd_q != '0) ? rrd_q - HW'(1) : '0);
    end

    always_comb begin
        cmd_ready = (state_q == ST_READY);
        rrd_ok    = (rrd_q == '0);
    end

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_mrs && (T_MRD > 1)) |=> !cmd_ready);

    // R9
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (do_ref && (T_RFC > 1)) |=> !cmd_ready);

    // R6
    open_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> (rrd_q == '0 && state_q == ST_READY));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 13,
    parameter int COL_W     = 9,
    parameter int T_RCD     = 2,
    parameter int T_RAS     = 5,
    parameter int T_RC      = 7,
    parameter int T_RP      = 2,
    parameter int T_RRD     = 2,
    parameter int T_MRD     = 2,
    parameter int T_DPL     = 2,
    parameter int T_DAL     = 5
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         req_valid,
    input  logic [2:0]                   req_op,
    input  logic [$clog2(NUM_BANKS)-1:0] req_bank,
    input  logic [ROW_W-1:0]             req_addr,
    input  logic                         req_flag,
    output logic                         req_ready,
    output logic                         req_error,
    output logic                         cs_n,
    output logic                         ras_n,
    output logic                         cas_n,
    output logic                         we_n,
    output logic [$clog2(NUM_BANKS)-1:0] ba,
    output logic [ROW_W-1:0]             addr,
    output logic [NUM_BANKS-1:0]         bank_open
);

    localparam int BA_W   = $clog2(NUM_BANKS);
    localparam int AP_BIT = 10;
    localparam int CW     = $clog2(T_RC + T_RAS + T_RP + T_DAL + T_DPL + 2);
    localparam int HW     = $clog2(T_MRD + T_RC + T_RRD + 2);

    req_op_e              op;
    logic [NUM_BANKS-1:0] bank_hit, open_w, rcd_ok, pre_ok, act_ok;
    logic [NUM_BANKS-1:0] do_act, do_rd, do_wr, do_pre;
    logic                 fsm_ready, rrd_ok, illegal, timing_ok, issue;
    cmd_pins_t            pins_n, pins_q;
    logic [BA_W-1:0]      ba_n, ba_q;
    logic [ROW_W-1:0]     addr_n, addr_q;

    assign op = req_op_e'(req_op);

    always_comb begin
        for (int b = 0; b < NUM_BANKS; b++) bank_hit[b] = (req_bank == BA_W'(b));
    end

    always_comb begin
        illegal   = 1'b0;
        timing_ok = 1'b0;
        unique case (op)
            REQ_ACT: begin
                illegal   = |(open_w & bank_hit);
                timing_ok = rrd_ok & |(act_ok & bank_hit);
            end
            REQ_RD, REQ_WR: begin
                illegal   = ~|(open_w & bank_hit);
                timing_ok = |(rcd_ok & bank_hit);
            end
            REQ_PRE: begin
                timing_ok = req_flag ? &(pre_ok | ~open_w)
                                     : |((pre_ok | ~open_w) & bank_hit);
            end
            REQ_MRS, REQ_REF: begin
                illegal   = |open_w;
                timing_ok = &act_ok;
            end
            REQ_BST: timing_ok = 1'b1;
            REQ_RSV: illegal   = 1'b1;
        endcase
    end

    assign req_ready = fsm_ready & (illegal | timing_ok);
    assign issue     = req_valid & req_ready & ~illegal;
    assign req_error = req_valid & req_ready & illegal;

    generate
        for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
            assign do_act[b] = issue & (op == REQ_ACT) & bank_hit[b];
            assign do_rd[b]  = issue & (op == REQ_RD)  & bank_hit[b];
            assign do_wr[b]  = issue & (op == REQ_WR)  & bank_hit[b];
            assign do_pre[b] = issue & (op == REQ_PRE) & (req_flag | bank_hit[b]);

            sdram_bank_timer #(
                .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP),
                .T_DPL(T_DPL), .T_DAL(T_DAL), .CW(CW)
            ) u_timer (
                .clk     (clk),
                .rst_n   (rst_n),
                .do_act  (do_act[b]),
                .do_rd   (do_rd[b]),
                .do_wr   (do_wr[b]),
                .do_pre  (do_pre[b]),
                .auto_pc (req_flag),
                .row_open(open_w[b]),
                .rcd_ok  (rcd_ok[b]),
                .pre_ok  (pre_ok[b]),
                .act_ok  (act_ok[b])
            );
        end
    endgenerate

    sdram_seq_fsm #(
        .T_MRD(T_MRD), .T_RFC(T_RC), .T_RRD(T_RRD), .HW(HW)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .do_mrs   (issue & (op == REQ_MRS)),
        .do_ref   (issue & (op == REQ_REF)),
        .do_act   (|do_act),
        .cmd_ready(fsm_ready),
        .rrd_ok   (rrd_ok)
    );

    always_comb begin
        pins_n = PINS_NOP;
        ba_n   = '0;
        addr_n = '0;
        if (issue) begin
            ba_n = req_bank;
            unique case (op)
                REQ_ACT: begin
                    pins_n = PINS_ACT;
                    addr_n = req_addr;
                end
                REQ_RD, REQ_WR: begin
                    pins_n = (op == REQ_RD) ? PINS_RD : PINS_WR;
                    addr_n[COL_W-1:0] = req_addr[COL_W-1:0];
                    addr_n[AP_BIT]    = req_flag;
                end
                REQ_PRE: begin
                    pins_n = PINS_PRE;
                    addr_n[AP_BIT] = req_flag;
                end
                REQ_MRS: begin
                    pins_n = PINS_MRS;
                    addr_n = req_addr;
                end
                REQ_REF: pins_n = PINS_REF;
                REQ_BST: pins_n = PINS_BST;
                REQ_RSV: pins_n = PINS_NOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pins_q <= PINS_DESEL;
            ba_q   <= '0;
            addr_q <= '0;
        end else begin
            pins_q <= pins_n;
            ba_q   <= ba_n;
            addr_q <= addr_n;
        end
    end

    assign cs_n      = pins_q.cs_n;
    assign ras_n     = pins_q.ras_n;
    assign cas_n     = pins_q.cas_n;
    assign we_n      = pins_q.we_n;
    assign ba        = ba_q;
    assign addr      = addr_q;
    assign bank_open = open_w;

    // R3
    issue_drives_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> !cs_n);

    // R10
    refuse_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_error |=> ({cs_n, ras_n, cas_n, we_n} == 4'b0111));

    // R9
    ref_all_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && op == REQ_REF) |-> (open_w == '0 && act_ok == '1));

endmodule

// File: tb/tb_sdram_cmd_seq.sv
module tb_sdram_cmd_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 18;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [2:0]  req_op;
    logic [1:0]  req_bank;
    logic [12:0] req_addr;
    logic        req_flag;
    logic        req_ready, req_error;
    logic        cs_n, ras_n, cas_n, we_n;
    logic [1:0]  ba;
    logic [12:0] addr;
    logic [3:0]  bank_open;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    sdram_cmd_seq dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_bank(req_bank), .req_addr(req_addr), .req_flag(req_flag),
        .req_ready(req_ready), .req_error(req_error), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .bank_open(bank_open)
    );

    // op, bank, addr, flag | wait, err, pins, ba, addr, bank_open
    localparam logic [46:0] VEC [NV] = '{
        {3'd4, 2'd0, 13'h0032, 1'b0, 4'd0, 1'b0, 4'b0000, 2'd0, 13'h0032, 4'b0000},
        {3'd0, 2'd0, 13'h1ABC, 1'b0, 4'd1, 1'b0, 4'b0011, 2'd0, 13'h1ABC, 4'b0001},
        {3'd0, 2'd1, 13'h0055, 1'b0, 4'd1, 1'b0, 4'b0011, 2'd1, 13'h0055, 4'b0011},
        {3'd1, 2'd0, 13'h001F, 1'b0, 4'd0, 1'b0, 4'b0101, 2'd0, 13'h001F, 4'b0011},
        {3'd2, 2'd1, 13'h0100, 1'b0, 4'd0, 1'b0, 4'b0100, 2'd1, 13'h0100, 4'b0011},
        {3'd3, 2'd0, 13'h0000, 1'b0, 4'd0, 1'b0, 4'b0010, 2'd0, 13'h0000, 4'b0010},
        {3'd0, 2'd0, 13'h0001, 1'b0, 4'd1, 1'b0, 4'b0011, 2'd0, 13'h0001, 4'b0011},
        {3'd2, 2'd0, 13'h1E03, 1'b1, 4'd1, 1'b0, 4'b0100, 2'd0, 13'h0403, 4'b0010},
        {3'd1, 2'd0, 13'h0005, 1'b0, 4'd0, 1'b1, 4'b0111, 2'd0, 13'h0000, 4'b0010},
        {3'd3, 2'd2, 13'h0000, 1'b1, 4'd0, 1'b0, 4'b0010, 2'd2, 13'h0400, 4'b0000},
        {3'd5, 2'd0, 13'h0000, 1'b0, 4'd2, 1'b0, 4'b0001, 2'd0, 13'h0000, 4'b0000},
        {3'd0, 2'd2, 13'h0ABC, 1'b0, 4'd6, 1'b0, 4'b0011, 2'd2, 13'h0ABC, 4'b0100},
        {3'd0, 2'd2, 13'h0001, 1'b0, 4'd0, 1'b1, 4'b0111, 2'd0, 13'h0000, 4'b0100},
        {3'd5, 2'd0, 13'h0000, 1'b0, 4'd0, 1'b1, 4'b0111, 2'd0, 13'h0000, 4'b0100},
        {3'd1, 2'd2, 13'h0007, 1'b1, 4'd0, 1'b0, 4'b0101, 2'd2, 13'h0407, 4'b0000},
        {3'd0, 2'd2, 13'h0002, 1'b0, 4'd3, 1'b0, 4'b0011, 2'd2, 13'h0002, 4'b0100},
        {3'd6, 2'd0, 13'h0000, 1'b0, 4'd0, 1'b0, 4'b0110, 2'd0, 13'h0000, 4'b0100},
        {3'd7, 2'd1, 13'h0000, 1'b0, 4'd0, 1'b1, 4'b0111, 2'd0, 13'h0000, 4'b0100}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic run_req(input logic [2:0] op, input logic [1:0] bk, input logic [12:0] ad,
                           input logic fl, output int waited, output logic err);
        req_valid = 1'b1; req_op = op; req_bank = bk; req_addr = ad; req_flag = fl;
        waited = 0;
        #1;
        while (!req_ready && waited < 40) begin
            @(negedge clk);
            waited++;
            #1;
        end
        err = req_error;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int   w;
        logic e;
        rst_n = 1'b0; req_valid = 1'b0; req_op = '0; req_bank = '0;
        req_addr = '0; req_flag = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 reset deselect", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
        check("R11 reset bank_open", bank_open, 4'b0000);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            run_req(VEC[i][46:44], VEC[i][43:42], VEC[i][41:29], VEC[i][28], w, e);
            check($sformatf("R4/R5/R6/R7/R8/R9 wait vec%0d", i), w, VEC[i][27:24]);
            check($sformatf("R10 error vec%0d", i), e, VEC[i][23]);
            check($sformatf("R1 pins vec%0d", i), {cs_n, ras_n, cas_n, we_n}, VEC[i][22:19]);
            check($sformatf("R2 ba vec%0d", i), ba, VEC[i][18:17]);
            check($sformatf("R2 addr vec%0d", i), addr, VEC[i][16:4]);
            check($sformatf("R11 open vec%0d", i), bank_open, VEC[i][3:0]);
        end

        // R3: idle cycle after last command shows no-operation
        @(negedge clk);
        check("R3 idle nop", {cs_n, ras_n, cas_n, we_n, ba, addr}, {4'b0111, 2'd0, 13'h0});

        // R11: reset with a bank open clears the flags
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R11 reset clears open", bank_open, 4'b0000);
        check("R3 reset deselect again", {cs_n, ras_n, cas_n, we_n}, 4'b1111);
        rst_n = 1'b1;

        // R6: counters satisfied out of reset, open row taken at once
        run_req(3'd0, 2'd3, 13'h0003, 1'b0, w, e);
        check("R6 no wait after reset", w, 0);
        check("R1 open row pins after reset", {cs_n, ras_n, cas_n, we_n}, 4'b0011);
        check("R11 bank3 open", bank_open, 4'b1000);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule